// File: doc/BRIEF.md
# Disk Drive Control Output Register

This block is the host-facing control register of a floppy-style disk interface, together with the logic it drives. A byte bus with separate read and write strobes reaches it at a configurable offset (default 2). The stored byte selects one of four drives through a binary field, switches four spindle motors on or off, holds the disk controller in software reset, and opens or closes the DMA request, interrupt, DMA acknowledge and terminal count paths.

Whether those handshake paths are open depends on the interface mode pin. In the two AT-style modes a register bit opens them. In PS/2 mode they are always open. Writing the register's own reset bit never clears the register. The block also widens every soft-reset request to a minimum pulse length, so a clear-then-set pair of writes on consecutive cycles still gives a usable reset. A second read-only location (default offset 1) returns the active-low state of the first two drive selects and of a drive-type input pin.

Top module: `disk_outctl`

## Requirements
- R1: While hardware reset `rstN` is low, the register reads 0x00, `driveSelN` is 4'b1110, `motorOn` is 0, `softRst` is 1, and in AT mode `drqOe`=0, `intOe`=0, `dackN`=1, `tcOut`=0.
- R2: A write with `busAddr` equal to the control offset (default 2) stores `busWrData` whole. A read at that offset returns exactly the stored byte. Writes to any other offset leave the register and all outputs unchanged.
- R3: Bits 1:0 hold a drive number n. On the clock edge that captures the write, `driveSelN[n]` goes low and the other three go high. Exactly one select is low at all times.
- R4: Bits 7:4 map to `motorOn[3:0]` (bit 4 drives motor 0). They update on the clock edge that captures the write.
- R5: Bit 2 is an active-low reset request. Once a write stores 0 there, `softRst` is 1 from the next edge and stays 1 until a write stores 1.
- R6: Every `softRst` pulse, including the one that follows hardware reset, lasts at least MIN_RST_CYC clock cycles (default 5). A clear write followed on the very next cycle by a set write gives a pulse of exactly MIN_RST_CYC cycles.
- R7: A software reset changes no bit of the register. After a clear-then-set sequence, a read returns the last byte written.
- R8: In interface modes `ifMode` = 2'b00, 2'b01 and 2'b11, bit 3 = 1 gives `drqOe`=`intOe`=1, `dackN`=`dackInN` and `tcOut`=`tcIn`. Bit 3 = 0 gives `drqOe`=`intOe`=0, `dackN`=1 and `tcOut`=0.
- R9: In interface mode `ifMode` = 2'b10, `drqOe`=`intOe`=1, `dackN`=`dackInN` and `tcOut`=`tcIn`, whatever bit 3 holds and whether or not a software reset is active.
- R10: A read at the status offset (default 1) returns `driveSelN[0]` in bit 5, `driveSelN[1]` in bit 6, `drv2N` in bit 7, and 0 in bits 4:0.
- R11: `busRdData` is 0x00 in every cycle without a read strobe, and in every cycle that reads an offset other than the control or status offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| busAddr | input | ADDR_W | Byte offset within the controller's address block |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data; zero when no mapped location is read |
| ifMode | input | 2 | Interface mode: 00 AT, 01 Model-30, 10 PS/2, 11 treated as AT |
| drv2N | input | 1 | Drive-type input pin, returned in status bit 7 |
| dackInN | input | 1 | DMA acknowledge from the host, active low |
| tcIn | input | 1 | Terminal count from the host |
| driveSelN | output | 4 | Drive selects, active low, exactly one low |
| motorOn | output | 4 | Motor enables, active high |
| softRst | output | 1 | Reset request to the disk controller core |
| drqOe | output | 1 | Output enable for the DMA request driver |
| intOe | output | 1 | Output enable for the interrupt driver |
| dackN | output | 1 | Gated DMA acknowledge, held high when the path is closed |
| tcOut | output | 1 | Gated terminal count, held low when the path is closed |

## Verification
On every cycle the assertions check several properties. Exactly one drive select is low. Drive selects and motors follow a captured write on the next edge and stay put otherwise. A cleared reset bit raises `softRst`, and no `softRst` pulse ends before the minimum width. PS/2 mode keeps the handshake paths open, and a closed path parks `dackN` high and `tcOut` low. The status bit positions and an idle read bus are also checked. Some behaviour shows up only in the bench's scenarios, which compare against a reference model each cycle. These are the exact reset values, the exact pulse length of a back-to-back clear-and-set pair, the register surviving a software reset unchanged, writes to other offsets being ignored, and the mode-by-DMA-bit gating table.

// File: rtl/disk_outctl_pkg.sv
package disk_outctl_pkg;

  localparam int DATA_W     = 8;
  localparam int NUM_DRIVES = 4;
  localparam int SEL_W      = $clog2(NUM_DRIVES);

  // Field positions inside the control byte
  localparam int SEL_LSB   = 0;
  localparam int RST_BIT   = 2;
  localparam int DMA_BIT   = 3;
  localparam int MOTOR_LSB = 4;

  // Field positions inside the status byte
  localparam int STAT_DS0_BIT = 5;
  localparam int STAT_DS1_BIT = 6;
  localparam int STAT_DRV_BIT = 7;

  typedef enum logic [1:0] {
    IF_AT   = 2'b00,
    IF_M30  = 2'b01,
    IF_PS2  = 2'b10,
    IF_RSVD = 2'b11
  } ifMode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrCtl;
    logic rdCtl;
    logic rdStat;
    logic rstHold;
  } ctlStrobe_t;

endpackage

// File: rtl/disk_outctl_ctrl.sv
module disk_outctl_ctrl
  import disk_outctl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTL_OFS     = 2,
  parameter int STAT_OFS    = 1,
  parameter int MIN_RST_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              wrRstBit,
  output ctlStrobe_t        strobe
);

  localparam int CNT_W = $clog2(MIN_RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_RST_CYC);

  logic hitCtl;
  logic hitStat;
  logic clearReq;
  logic [CNT_W-1:0] holdCnt;

  assign hitCtl  = (busAddr == ADDR_W'(CTL_OFS));
  assign hitStat = (busAddr == ADDR_W'(STAT_OFS));

  // A write that clears the reset bit starts a new minimum-width window
  assign clearReq = busWrEn & hitCtl & ~wrRstBit;

  // Pulse stretcher: also loaded by hardware reset so the first pulse is wide
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= CNT_LOAD;
    end else if (clearReq) begin
      holdCnt <= CNT_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.wrCtl   = busWrEn & hitCtl;
    strobe.rdCtl   = busRdEn & hitCtl;
    strobe.rdStat  = busRdEn & hitStat;
    strobe.rstHold = (holdCnt != '0);
  end

endmodule

// File: rtl/disk_outctl_dp.sv
module disk_outctl_dp
  import disk_outctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [1:0]            ifMode,
  input  logic                  drv2N,
  input  logic                  dackInN,
  input  logic                  tcIn,
  output logic [NUM_DRIVES-1:0] driveSelN,
  output logic [NUM_DRIVES-1:0] motorOn,
  output logic                  softRst,
  output logic                  drqOe,
  output logic                  intOe,
  output logic                  dackN,
  output logic                  tcOut
);

  // Drive 0 selected after reset, because the drive field clears to zero
  localparam logic [NUM_DRIVES-1:0] SEL_RST = ~{{(NUM_DRIVES-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0]     ctlQ;
  logic [NUM_DRIVES-1:0] selNQ;
  logic [NUM_DRIVES-1:0] motorQ;
  logic [NUM_DRIVES-1:0] selDecN;
  logic [NUM_DRIVES-1:0] motorNext;
  logic [SEL_W-1:0]      wrSel;
  logic                  pathOpen;
  ifMode_e               modeSel;

  assign wrSel = busWrData[SEL_LSB +: SEL_W];

  // Select decode and motor extraction for the write data
  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
    assign selDecN[g]   = (wrSel != SEL_W'(g));
    assign motorNext[g] = busWrData[MOTOR_LSB + g];
  end

  // Register and registered pin outputs update on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ   <= '0;
      selNQ  <= SEL_RST;
      motorQ <= '0;
    end else if (strobe.wrCtl) begin
      ctlQ   <= busWrData;
      selNQ  <= selDecN;
      motorQ <= motorNext;
    end
  end

  assign driveSelN = selNQ;
  assign motorOn   = motorQ;

  // Reset request: bit low, or the minimum-width window still running
  assign softRst = ~ctlQ[RST_BIT] | strobe.rstHold;

  // Handshake gating by interface mode
  assign modeSel  = ifMode_e'(ifMode);
  assign pathOpen = (modeSel == IF_PS2) | ctlQ[DMA_BIT];

  always_comb begin
    drqOe = pathOpen;
    intOe = pathOpen;
    dackN = pathOpen ? dackInN : 1'b1;
    tcOut = pathOpen ? tcIn    : 1'b0;
  end

  // Read mux
  always_comb begin
    busRdData = '0;
    if (strobe.rdCtl) begin
      busRdData = ctlQ;
    end else if (strobe.rdStat) begin
      busRdData[STAT_DS0_BIT] = selNQ[0];
      busRdData[STAT_DS1_BIT] = selNQ[1];
      busRdData[STAT_DRV_BIT] = drv2N;
    end
  end

endmodule

// File: rtl/disk_outctl.sv
module disk_outctl
  import disk_outctl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTL_OFS     = 2,
  parameter int STAT_OFS    = 1,
  parameter int MIN_RST_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [1:0]        ifMode,
  input  logic              drv2N,
  input  logic              dackInN,
  input  logic              tcIn,
  output logic [3:0]        driveSelN,
  output logic [3:0]        motorOn,
  output logic              softRst,
  output logic              drqOe,
  output logic              intOe,
  output logic              dackN,
  output logic              tcOut
);

  ctlStrobe_t strobe;

  disk_outctl_ctrl #(
    .ADDR_W      (ADDR_W),
    .CTL_OFS     (CTL_OFS),
    .STAT_OFS    (STAT_OFS),
    .MIN_RST_CYC (MIN_RST_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .wrRstBit (busWrData[RST_BIT]),
    .strobe   (strobe)
  );

  disk_outctl_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .ifMode    (ifMode),
    .drv2N     (drv2N),
    .dackInN   (dackInN),
    .tcIn      (tcIn),
    .driveSelN (driveSelN),
    .motorOn   (motorOn),
    .softRst   (softRst),
    .drqOe     (drqOe),
    .intOe     (intOe),
    .dackN     (dackN),
    .tcOut     (tcOut)
  );

endmodule

// File: rtl/disk_outctl_chk.sv
module disk_outctl_chk #(
  parameter int ADDR_W      = 3,
  parameter int CTL_OFS     = 2,
  parameter int STAT_OFS    = 1,
  parameter int MIN_RST_CYC = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [7:0]        busWrData,
  input logic [7:0]        busRdData,
  input logic [1:0]        ifMode,
  input logic              drv2N,
  input logic [3:0]        driveSelN,
  input logic [3:0]        motorOn,
  input logic              softRst,
  input logic              drqOe,
  input logic              intOe,
  input logic              dackN,
  input logic              tcOut
);

  logic ctlWr;
  logic [15:0] runLen;

  assign ctlWr = busWrEn && (busAddr == ADDR_W'(CTL_OFS));

  // Length of the current softRst pulse, in sampled cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (softRst) begin
      runLen <= (runLen == 16'hFFFF) ? runLen : runLen + 16'd1;
    end else begin
      runLen <= '0;
    end
  end

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~driveSelN) == 1);

  p_sel_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> !driveSelN[$past(busWrData[1:0])]);

  p_motor_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> motorOn == $past(busWrData[7:4]));

  p_outputs_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(motorOn) && $stable(driveSelN));

  p_rst_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !busWrData[2]) |=> softRst);

  p_min_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(softRst) |-> runLen >= 16'(MIN_RST_CYC));

  p_ps2_open_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ifMode == 2'b10) |-> drqOe && intOe);

  p_closed_park_r8: assert property (@(posedge clk) disable iff (!rstN)
    !drqOe |-> dackN && !tcOut && !intOe);

  p_stat_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(STAT_OFS)) |->
      busRdData[5] == driveSelN[0] && busRdData[6] == driveSelN[1] &&
      busRdData[7] == drv2N && busRdData[4:0] == 5'd0);

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> busRdData == 8'h00);

endmodule

bind disk_outctl disk_outctl_chk #(
  .ADDR_W      (ADDR_W),
  .CTL_OFS     (CTL_OFS),
  .STAT_OFS    (STAT_OFS),
  .MIN_RST_CYC (MIN_RST_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .ifMode    (ifMode),
  .drv2N     (drv2N),
  .driveSelN (driveSelN),
  .motorOn   (motorOn),
  .softRst   (softRst),
  .drqOe     (drqOe),
  .intOe     (intOe),
  .dackN     (dackN),
  .tcOut     (tcOut)
);

// File: tb/disk_outctl_bench.sv
module disk_outctl_bench;

  localparam int MIN_RST = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = 3'd2;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [1:0] ifMode = 2'b00;
  logic       drv2N = 1'b1;
  logic       dackInN = 1'b1;
  logic       tcIn = 1'b0;
  logic [3:0] driveSelN;
  logic [3:0] motorOn;
  logic       softRst;
  logic       drqOe;
  logic       intOe;
  logic       dackN;
  logic       tcOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  disk_outctl #(.MIN_RST_CYC(MIN_RST)) u_disk_outctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .ifMode(ifMode), .drv2N(drv2N), .dackInN(dackInN), .tcIn(tcIn),
    .driveSelN(driveSelN), .motorOn(motorOn), .softRst(softRst),
    .drqOe(drqOe), .intOe(intOe), .dackN(dackN), .tcOut(tcOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [7:0] mReg = 8'h00;
  int         mHold = MIN_RST;

  always @(posedge clk) begin
    if (!rstN) begin
      mReg  = 8'h00;
      mHold = MIN_RST;
    end else begin
      if (mHold > 0) mHold = mHold - 1;
      if (busWrEn && busAddr == 3'd2) begin
        mReg = busWrData;
        if (!busWrData[2]) mHold = MIN_RST;
      end
    end
  end

  // Compare against the model in the middle of every cycle
  always @(negedge clk) begin
    if (rstN) begin
      logic [3:0] eSel;
      logic       eOpen;
      logic [7:0] eRd;
      string      gTag;
      string      rTag;
      eSel  = ~(4'b0001 << mReg[1:0]);
      eOpen = (ifMode == 2'b10) || mReg[3];
      gTag  = (ifMode == 2'b10) ? "R9" : "R8";
      eRd   = 8'h00;
      rTag  = "R11";
      if (busRdEn && busAddr == 3'd2) begin
        eRd  = mReg;
        rTag = "R2";
      end else if (busRdEn && busAddr == 3'd1) begin
        eRd  = {drv2N, eSel[1], eSel[0], 5'b00000};
        rTag = "R10";
      end
      chk("R3 driveSelN", 16'(driveSelN), 16'(eSel));
      chk("R4 motorOn", 16'(motorOn), 16'(mReg[7:4]));
      chk("R5 softRst", 16'(softRst), 16'(!mReg[2] || mHold > 0));
      chk({gTag, " drqOe"}, 16'(drqOe), 16'(eOpen));
      chk({gTag, " intOe"}, 16'(intOe), 16'(eOpen));
      chk({gTag, " dackN"}, 16'(dackN), 16'(eOpen ? dackInN : 1'b1));
      chk({gTag, " tcOut"}, 16'(tcOut), 16'(eOpen ? tcIn : 1'b0));
      chk({rTag, " busRdData"}, 16'(busRdData), 16'(eRd));
    end
  end

  // Length of the most recent completed softRst pulse
  int run = 0;
  int lastRun = 0;
  always @(negedge clk) begin
    if (!rstN) run = 0;
    else if (softRst) run = run + 1;
    else begin
      if (run > 0) lastRun = run;
      run = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busRdEn = 1'b0; busAddr = a; busWrData = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    busWrEn = 1'b0; busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    v = busRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      busWrEn = 1'b0; busRdEn = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    logic [15:0] lfsr;
    // R1: reset state, reading the control offset during reset
    busRdEn = 1'b1; busAddr = 3'd2;
    repeat (3) @(negedge clk);
    chk("R1 busRdData", 16'(busRdData), 16'h00);
    chk("R1 driveSelN", 16'(driveSelN), 16'hE);
    chk("R1 motorOn", 16'(motorOn), 16'h0);
    chk("R1 softRst", 16'(softRst), 16'h1);
    chk("R1 drqOe", 16'(drqOe), 16'h0);
    chk("R1 intOe", 16'(intOe), 16'h0);
    chk("R1 dackN", 16'(dackN), 16'h1);
    chk("R1 tcOut", 16'(tcOut), 16'h0);
    @(posedge clk); #1;
    rstN = 1'b1; busRdEn = 1'b0;
    idle(8);

    // R3, R4: each drive with a different motor pattern
    wr(3'd2, 8'h14); wr(3'd2, 8'h25); wr(3'd2, 8'h46); wr(3'd2, 8'h87);
    wr(3'd2, 8'hF4); idle(2);
    rd(3'd2, v); chk("R2 readback", 16'(v), 16'hF4);

    // R10: status bits with both drv2N levels
    wr(3'd2, 8'h05); drv2N = 1'b0;
    rd(3'd1, v); chk("R10 status ds1 low", 16'(v), 16'h20);
    drv2N = 1'b1;
    rd(3'd1, v); chk("R10 status drv2N", 16'(v), 16'hA0);

    // R6, R7: clear then set on consecutive cycles
    wr(3'd2, 8'h31); wr(3'd2, 8'h35); idle(MIN_RST + 3);
    chk("R6 pulse width", 16'(lastRun), 16'(MIN_RST));
    rd(3'd2, v); chk("R7 register kept", 16'(v), 16'h35);

    // R5: long reset held until the bit is set again
    wr(3'd2, 8'hA2); idle(MIN_RST + 8);
    @(negedge clk); chk("R5 still held", 16'(softRst), 16'h1);
    wr(3'd2, 8'hA6); idle(1);
    @(negedge clk); chk("R5 released", 16'(softRst), 16'h0);
    rd(3'd2, v); chk("R7 after long reset", 16'(v), 16'hA6);

    // R2: writes elsewhere are ignored
    wr(3'd0, 8'hFF); wr(3'd3, 8'h00); wr(3'd7, 8'h5A); wr(3'd1, 8'h13); idle(1);
    rd(3'd2, v); chk("R2 other offsets ignored", 16'(v), 16'hA6);
    chk("R2 motors kept", 16'(motorOn), 16'hA);
    rd(3'd5, v); chk("R11 unmapped read", 16'(v), 16'h00);

    // R8, R9: every mode against both DMA bit values, also during soft reset
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < 2; r++) begin
          ifMode = 2'(m);
          wr(3'd2, {4'b0011, 1'(d), 1'(r), 2'b01});
          for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            busWrEn = 1'b0;
            dackInN = k[0]; tcIn = k[1];
          end
        end
      end
    end
    ifMode = 2'b00;
    wr(3'd2, 8'h04); idle(MIN_RST + 2);

    // Mixed traffic driven by a shift register
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ifMode  = lfsr[9:8];
      drv2N   = lfsr[11];
      dackInN = lfsr[12];
      tcIn    = lfsr[13];
      case (lfsr[1:0])
        2'd0, 2'd1: wr((lfsr[2] ? 3'd2 : lfsr[6:4]), lfsr[15:8] | 8'h04);
        2'd2:       rd(lfsr[6:4], v);
        default:    wr(3'd2, lfsr[15:8]);
      endcase
    end
    idle(MIN_RST + 2);
    finishRun();
  end

endmodule